// File: doc/BRIEF.md
# Asynchronous Memory Bus Controller

This block turns single 32-bit internal read and write requests into cycles on an asynchronous external bus. SRAM, ROM, flash parts and memory-mapped peripherals sit on that bus. The request carries a word address. Its top field selects one of up to six chip-enable regions, and the remaining bits form a 26-bit byte address inside that region.

Each region has three settings: its own wait count, a data bus width of 8 or 16 bits, and a byte-lane style. A request to a narrow region is split into several bus cycles. Every bus cycle has a fixed shape: one setup cycle, then a strobe phase, then one hold cycle. The strobe phase lasts at least the programmed number of wait cycles. After that count, an active-low wait input from the device can stretch it further.

The internal side uses a simple handshake. A request is accepted while `reqReady` is high. Completion is signalled by a one-cycle `reqDone` pulse, with read data valid in that cycle.

Top module: `xmemBusCtl`

## Requirements
- R1: While reset is applied and after it is released, all chip enables, `busRdN` and `busWrN` are high, `busDataOe` and `reqDone` are low, and `reqReady` is high.
- R2: Request word-address bits [26:24] select the region. Region value n below 6 drives only `busCeN[n]` low during the access. The values 6 and 7 produce a `reqDone` one cycle after acceptance, with no chip enable or strobe activity, and the read data is zero.
- R3: A request to a region whose width bit is 1 (16-bit) makes two bus cycles. The first is at byte address {word,00} and the second at that address plus 2.
- R4: A request to a region whose width bit is 0 (8-bit) makes four bus cycles at byte addresses {word,00} up to {word,11}, with data on the low 8 bus lines.
- R5: With `busWaitN` held high, each strobe phase (`busRdN` or `busWrN` low) lasts exactly the region's 4-bit wait value plus one cycles. Values 0 to 15 are valid.
- R6: `busWaitN` is looked at only once the wait count has run out. For wait value w, if `busWaitN` is low for the first L cycles of the strobe phase, the phase lasts max(w, L) + 1 cycles.
- R7: Every bus cycle begins with one setup cycle and ends with one hold cycle. In both, the region's chip enable is low and both strobes are high. The address stays unchanged throughout the strobe phase.
- R8: During an access, `busBsN` is 2'b11 for a region whose strobe-style bit is 0, where bytes are selected by address bit 0. For a strobe-style region it is 2'b00 on a 16-bit bus and 2'b10 (low lane only) on an 8-bit bus.
- R9: Byte order is little endian. The lowest byte of the write data goes out in the first bus cycle. Read data is assembled the same way, so the byte at the lowest bus address lands in bits [7:0].
- R10: `reqReady` is low while any chip enable is active. `reqDone` is high for exactly one cycle, the cycle after the hold cycle of the final bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 27 | Word address: [26:24] region, [23:0] word within region |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqDone | output | 1 | One-cycle completion pulse |
| reqRdata | output | 32 | Read data, valid with reqDone |
| cfgWait | input | 24 | Wait count per region, 4 bits each, region n at [4n+3:4n] |
| cfgWide | input | 6 | Per region: 1 selects 16-bit bus, 0 selects 8-bit bus |
| cfgStrobe | input | 6 | Per region: 1 selects byte-strobe style, 0 selects address-bit-0 style |
| busCeN | output | 6 | Active-low chip enables |
| busAddr | output | 26 | External byte address |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |
| busBsN | output | 2 | Active-low byte-lane strobes |
| busDataOut | output | 16 | Write data driven to the bus |
| busDataOe | output | 1 | Output enable for busDataOut |
| busDataIn | input | 16 | Read data from the bus |
| busWaitN | input | 1 | Active-low wait request from the device |

## Verification
The bench drives the wait input low for chosen stretches, some shorter and some longer than the programmed wait count. A controller that samples the pin too early would lengthen accesses that should not change, and one that ignores it would cut stretched accesses short.

Narrow and wide regions are mixed with both byte-lane styles and with the wait extremes 0 and 15. Getting the split or the lane order wrong shows up as swapped or missing bytes in read data or in the bus model's memory, or as wrong beat addresses.

Out-of-range region values are sent as well. A decoder that wraps them would wrongly fire a chip enable or return stale read data.

// File: rtl/xmemPkg.sv
package xmemPkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phaseT;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // take a new request
    logic capture;    // last strobe cycle of a beat: grab read data
    logic nextBeat;   // advance to next beat
    logic selActive;  // chip enable asserted
    logic strobeOn;   // read/write strobe asserted
  } ctlStrobeT;
endpackage

// File: rtl/xmemControl.sv
module xmemControl
  import xmemPkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqInRange,
  input  logic [WAIT_W-1:0] waitLoad,
  input  logic              lastBeat,
  input  logic              busWaitN,
  output ctlStrobeT         ctl,
  output logic              reqReady,
  output logic              reqDone
);
  phaseT             phase;
  logic [WAIT_W-1:0] waitCnt;
  logic              countDone;

  assign countDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      waitCnt <= '0;
      reqDone <= 1'b0;
    end else begin
      reqDone <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            if (reqInRange) phase <= PH_SETUP;
            else            reqDone <= 1'b1;
          end
        end
        PH_SETUP: begin
          phase   <= PH_STROBE;
          waitCnt <= waitLoad;
        end
        PH_STROBE: begin
          if (!countDone)    waitCnt <= waitCnt - 1'b1;
          else if (busWaitN) phase   <= PH_HOLD;
        end
        PH_HOLD: begin
          if (lastBeat) begin
            phase   <= PH_IDLE;
            reqDone <= 1'b1;
          end else begin
            phase <= PH_SETUP;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.latchReq  = (phase == PH_IDLE) && reqValid;
    ctl.capture   = (phase == PH_STROBE) && countDone && busWaitN;
    ctl.nextBeat  = (phase == PH_HOLD) && !lastBeat;
    ctl.selActive = (phase != PH_IDLE);
    ctl.strobeOn  = (phase == PH_STROBE);
    reqReady      = (phase == PH_IDLE);
  end
endmodule

// File: rtl/xmemDatapath.sv
module xmemDatapath
  import xmemPkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 26,
  parameter int WAIT_W = 4,
  parameter int SEL_W  = 3,
  parameter int REQ_AW = 27
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobeT                ctl,
  input  logic                     reqWrite,
  input  logic [REQ_AW-1:0]        reqAddr,
  input  logic [31:0]              reqWdata,
  input  logic [NUM_CS*WAIT_W-1:0] cfgWait,
  input  logic [NUM_CS-1:0]        cfgWide,
  input  logic [NUM_CS-1:0]        cfgStrobe,
  input  logic [15:0]              busDataIn,
  output logic                     reqInRange,
  output logic                     lastBeat,
  output logic [WAIT_W-1:0]        waitLoad,
  output logic [31:0]              reqRdata,
  output logic [NUM_CS-1:0]        busCeN,
  output logic [ADDR_W-1:0]        busAddr,
  output logic                     busRdN,
  output logic                     busWrN,
  output logic [1:0]               busBsN,
  output logic [15:0]              busDataOut,
  output logic                     busDataOe
);
  localparam int WORD_W = ADDR_W - 2;

  logic [SEL_W-1:0]  reqSel, selQ;
  logic [WORD_W-1:0] wordQ;
  logic              writeQ, wideQ, strobeQ;
  logic [31:0]       wdataQ, rdataQ;
  logic [1:0]        beatQ, byteOff;
  logic [WAIT_W-1:0] waitQ, waitPick;
  logic              widePick, strobePick;
  logic [7:0]        laneByte;

  assign reqSel     = reqAddr[REQ_AW-1 -: SEL_W];
  assign reqInRange = (int'(reqSel) < NUM_CS);

  // Per-region configuration lookup
  always_comb begin
    waitPick   = '0;
    widePick   = 1'b0;
    strobePick = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (reqSel == SEL_W'(i)) begin
        waitPick   = cfgWait[i*WAIT_W +: WAIT_W];
        widePick   = cfgWide[i];
        strobePick = cfgStrobe[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= '0;
      wordQ   <= '0;
      writeQ  <= 1'b0;
      wideQ   <= 1'b0;
      strobeQ <= 1'b0;
      wdataQ  <= '0;
      rdataQ  <= '0;
      beatQ   <= '0;
      waitQ   <= '0;
    end else begin
      if (ctl.latchReq) begin
        selQ    <= reqSel;
        wordQ   <= reqAddr[WORD_W-1:0];
        writeQ  <= reqWrite;
        wideQ   <= widePick;
        strobeQ <= strobePick;
        wdataQ  <= reqWdata;
        rdataQ  <= '0;
        beatQ   <= '0;
        waitQ   <= waitPick;
      end
      if (ctl.capture && !writeQ) begin
        for (int k = 0; k < 4; k++) begin
          if (wideQ ? (beatQ[0] == 1'(k / 2)) : (beatQ == 2'(k)))
            rdataQ[8*k +: 8] <= wideQ ? busDataIn[8*(k%2) +: 8] : busDataIn[7:0];
        end
      end
      if (ctl.nextBeat) beatQ <= beatQ + 2'd1;
    end
  end

  assign byteOff  = wideQ ? {beatQ[0], 1'b0} : beatQ;
  assign lastBeat = wideQ ? beatQ[0] : (beatQ == 2'd3);
  assign waitLoad = waitQ;
  assign reqRdata = rdataQ;
  assign busAddr  = {wordQ, byteOff};

  always_comb begin
    unique case (beatQ)
      2'd0:    laneByte = wdataQ[7:0];
      2'd1:    laneByte = wdataQ[15:8];
      2'd2:    laneByte = wdataQ[23:16];
      default: laneByte = wdataQ[31:24];
    endcase
  end

  assign busDataOut = wideQ ? (beatQ[0] ? wdataQ[31:16] : wdataQ[15:0]) : {8'h00, laneByte};
  assign busDataOe  = ctl.selActive && writeQ;
  assign busRdN     = !(ctl.strobeOn && !writeQ);
  assign busWrN     = !(ctl.strobeOn && writeQ);
  assign busBsN     = (!ctl.selActive || !strobeQ) ? 2'b11 : (wideQ ? 2'b00 : 2'b10);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign busCeN[g] = !(ctl.selActive && (selQ == SEL_W'(g)));
  end
endmodule

// File: rtl/xmemBusCtl.sv
module xmemBusCtl
  import xmemPkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 26,
  parameter int WAIT_W = 4,
  localparam int SEL_W  = $clog2(NUM_CS),
  localparam int REQ_AW = SEL_W + ADDR_W - 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [REQ_AW-1:0]        reqAddr,
  input  logic [31:0]              reqWdata,
  output logic                     reqReady,
  output logic                     reqDone,
  output logic [31:0]              reqRdata,
  input  logic [NUM_CS*WAIT_W-1:0] cfgWait,
  input  logic [NUM_CS-1:0]        cfgWide,
  input  logic [NUM_CS-1:0]        cfgStrobe,
  output logic [NUM_CS-1:0]        busCeN,
  output logic [ADDR_W-1:0]        busAddr,
  output logic                     busRdN,
  output logic                     busWrN,
  output logic [1:0]               busBsN,
  output logic [15:0]              busDataOut,
  output logic                     busDataOe,
  input  logic [15:0]              busDataIn,
  input  logic                     busWaitN
);
  ctlStrobeT         ctl;
  logic              reqInRange, lastBeat;
  logic [WAIT_W-1:0] waitLoad;

  xmemControl #(.WAIT_W(WAIT_W)) u_control (
    .clk, .rstN, .reqValid, .reqInRange, .waitLoad, .lastBeat, .busWaitN,
    .ctl, .reqReady, .reqDone
  );

  xmemDatapath #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .SEL_W(SEL_W), .REQ_AW(REQ_AW)
  ) u_datapath (
    .clk, .rstN, .ctl, .reqWrite, .reqAddr, .reqWdata, .cfgWait, .cfgWide, .cfgStrobe,
    .busDataIn, .reqInRange, .lastBeat, .waitLoad, .reqRdata, .busCeN, .busAddr,
    .busRdN, .busWrN, .busBsN, .busDataOut, .busDataOe
  );
endmodule

// File: rtl/xmemBusCtlChk.sv
module xmemBusCtlChk #(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 26,
  parameter int WAIT_W = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     reqReady,
  input logic                     reqDone,
  input logic [NUM_CS*WAIT_W-1:0] cfgWait,
  input logic [NUM_CS-1:0]        busCeN,
  input logic [ADDR_W-1:0]        busAddr,
  input logic                     busRdN,
  input logic                     busWrN,
  input logic [1:0]               busBsN,
  input logic                     busDataOe
);
  localparam int RUN_W = WAIT_W + 4;

  logic              strobeOn;
  logic [RUN_W-1:0]  runLen;
  logic [WAIT_W-1:0] curWait;

  assign strobeOn = !busRdN || !busWrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 runLen <= '0;
    else if (!strobeOn)        runLen <= '0;
    else if (runLen != '1)     runLen <= runLen + 1'b1;
  end

  always_comb begin
    curWait = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (!busCeN[i]) curWait = cfgWait[i*WAIT_W +: WAIT_W];
  end

  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(~busCeN)); // R2
  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(!busRdN && !busWrN)); // R7
  AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rstN) strobeOn |-> (busCeN != '1)); // R7
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && !$past(strobeOn)) |-> ($past(busCeN) == busCeN)); // R7
  AST_HOLD_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeOn && $past(strobeOn)) |-> ($past(busCeN) == busCeN)); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && $past(strobeOn)) |-> $stable(busAddr)); // R7
  AST_MIN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeOn && $past(strobeOn)) |-> (runLen > RUN_W'(curWait))); // R5
  AST_BS_LEGAL: assert property (@(posedge clk) disable iff (!rstN) busBsN != 2'b01); // R8
  AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rstN) busDataOe |-> busRdN); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) reqDone |=> !reqDone); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN) (busCeN != '1) |-> !reqReady); // R10
endmodule

bind xmemBusCtl xmemBusCtlChk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_chk (
  .clk, .rstN, .reqReady, .reqDone, .cfgWait, .busCeN, .busAddr, .busRdN, .busWrN,
  .busBsN, .busDataOe
);

// File: tb/xmemBusCtl_bench.sv
`timescale 1ns/1ps
module xmemBusCtl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [26:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, reqDone;
  logic [31:0] reqRdata;
  logic [23:0] cfgWait = '0;
  logic [5:0]  cfgWide = '0, cfgStrobe = '0;
  logic [5:0]  busCeN;
  logic [25:0] busAddr;
  logic        busRdN, busWrN, busDataOe;
  logic [1:0]  busBsN;
  logic [15:0] busDataOut;
  logic [15:0] busDataIn = '0;
  logic        busWaitN = 1'b1;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [0:5][0:255];

  always #4 clk = ~clk;

  xmemBusCtl u_xmemBusCtl (
    .clk, .rstN, .reqValid, .reqWrite, .reqAddr, .reqWdata, .reqReady, .reqDone, .reqRdata,
    .cfgWait, .cfgWide, .cfgStrobe, .busCeN, .busAddr, .busRdN, .busWrN, .busBsN,
    .busDataOut, .busDataOe, .busDataIn, .busWaitN
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic runAccess(input bit wr, input logic [26:0] a, input logic [31:0] wd, input int stretch);
    int sel = int'(a[26:24]);
    bit inRange = (sel < 6);
    bit wide = 1'b0, bsMode = 1'b0;
    int w = 0, nBeats = 0, step = 1;
    logic [25:0] base = {a[23:0], 2'b00};
    logic [7:0] bi = {a[5:0], 2'b00};
    logic [31:0] expRd = '0;
    logic [5:0] expCe = '0, prevCe = '0;
    logic [1:0] expBs = 2'b11;
    int beats = 0, runLen = 0, lastHold = -10, doneCyc = -1, doneCnt = 0;
    bit prevStrobe = 1'b0;
    if (inRange) begin
      wide   = cfgWide[sel];
      bsMode = cfgStrobe[sel];
      w      = int'(cfgWait[sel*4 +: 4]);
      nBeats = wide ? 2 : 4;
      step   = wide ? 2 : 1;
      expCe  = 6'(1 << sel);
      expBs  = !bsMode ? 2'b11 : (wide ? 2'b00 : 2'b10);
      expRd  = {mem[sel][8'(bi+3)], mem[sel][8'(bi+2)], mem[sel][8'(bi+1)], mem[sel][bi]};
    end
    @(negedge clk);
    check(reqReady, "R10", "ready before request", 32'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    for (int cyc = 0; cyc < 500; cyc++) begin
      logic [5:0] ce = ~busCeN;
      bit strobe = !busRdN || !busWrN;
      if (strobe && !prevStrobe) begin
        check(prevCe == expCe, "R7", "setup cycle chip enable", 32'(prevCe), 32'(expCe));
        check(ce == expCe, "R2", "chip enable", 32'(ce), 32'(expCe));
        check(busAddr == 26'(base + 26'(beats*step)), wide ? "R3" : "R4", "beat address",
              32'(busAddr), 32'(base + 26'(beats*step)));
        check(busBsN == expBs, "R8", "byte lane strobes", 32'(busBsN), 32'(expBs));
        if (wr) begin
          logic [15:0] expD = wide ? wd[16*beats +: 16] : {8'h00, wd[8*beats +: 8]};
          check(busDataOut == expD && busDataOe, "R9", "write beat data", 32'(busDataOut), 32'(expD));
        end
        runLen = 0;
      end
      if (strobe) begin
        runLen++;
        busWaitN = (runLen <= stretch) ? 1'b0 : 1'b1;
        if (inRange) begin
          if (wr) begin
            mem[sel][busAddr[7:0]] = busDataOut[7:0];
            if (wide) mem[sel][8'(busAddr[7:0] + 1)] = busDataOut[15:8];
          end else begin
            busDataIn = wide ? {mem[sel][8'(busAddr[7:0] + 1)], mem[sel][busAddr[7:0]]}
                             : {8'hxx & 8'h00, mem[sel][busAddr[7:0]]};
          end
        end
      end else begin
        busWaitN = 1'b1;
        if (prevStrobe) begin
          check(runLen == maxInt(w, stretch) + 1, (stretch > 0) ? "R6" : "R5", "strobe length",
                32'(runLen), 32'(maxInt(w, stretch) + 1));
          check(ce == expCe, "R7", "hold cycle chip enable", 32'(ce), 32'(expCe));
          beats++;
          lastHold = cyc;
        end
      end
      if (ce != 0 && reqReady) check(1'b0, "R10", "ready while busy", 1, 0);
      if (reqDone) begin
        doneCnt++;
        doneCyc = cyc;
        break;
      end
      prevStrobe = strobe;
      prevCe = ce;
      @(negedge clk);
    end
    check(doneCnt == 1, "R10", "done seen", 32'(doneCnt), 1);
    check(beats == nBeats, inRange ? (wide ? "R3" : "R4") : "R2", "beat count", 32'(beats), 32'(nBeats));
    check(doneCyc == (inRange ? lastHold + 1 : 0), "R10", "done timing", 32'(doneCyc),
          32'(inRange ? lastHold + 1 : 0));
    if (!wr) begin
      check(reqRdata == expRd, inRange ? "R9" : "R2", "read data", reqRdata, expRd);
    end else if (inRange) begin
      logic [31:0] got = {mem[sel][8'(bi+3)], mem[sel][8'(bi+2)], mem[sel][8'(bi+1)], mem[sel][bi]};
      check(got == wd, "R9", "written bytes", got, wd);
    end
    @(negedge clk);
    check(!reqDone, "R10", "done one cycle only", 32'(reqDone), 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int r = 0; r < 6; r++)
      for (int b = 0; b < 256; b++) mem[r][b] = 8'($urandom);
    // region: 0 narrow/a0/w0 1 wide/strobe/w3 2 narrow/strobe/w15 3 wide/a0/w1 4 wide/strobe/w0 5 narrow/a0/w7
    cfgWait   = {4'd7, 4'd0, 4'd1, 4'd15, 4'd3, 4'd0};
    cfgWide   = 6'b011010;
    cfgStrobe = 6'b010110;
    repeat (2) @(negedge clk);
    check(busCeN == 6'h3f && busRdN && busWrN && !busDataOe && !reqDone && reqReady, "R1",
          "outputs in reset", {busCeN, busRdN, busWrN, busDataOe, reqDone, reqReady}, 32'h7f9);
    rstN = 1'b1;
    @(negedge clk);
    check(busCeN == 6'h3f && busRdN && busWrN && !reqDone && reqReady, "R1",
          "outputs after reset", {26'b0, busCeN}, 32'h3f);
    // directed: each region write then read back
    for (int r = 0; r < 6; r++) begin
      logic [26:0] a = {3'(r), 24'($urandom)};
      logic [31:0] d = $urandom;
      runAccess(1'b1, a, d, 0);
      runAccess(1'b0, a, 32'h0, 0);
    end
    // R6: wait pin low only inside count (no effect), then past it
    runAccess(1'b0, {3'd1, 24'h000010}, 32'h0, 2);
    runAccess(1'b0, {3'd1, 24'h000011}, 32'h0, 6);
    runAccess(1'b1, {3'd0, 24'h000012}, 32'h11223344, 5);
    runAccess(1'b0, {3'd2, 24'h000013}, 32'h0, 15);
    runAccess(1'b0, {3'd2, 24'h000014}, 32'h0, 17);
    // R2: regions out of range
    runAccess(1'b0, {3'd6, 24'h000001}, 32'h0, 0);
    runAccess(1'b1, {3'd7, 24'h000002}, 32'hdeadbeef, 0);
    runAccess(1'b0, {3'd7, 24'h000003}, 32'h0, 0);
    // random mix
    for (int n = 0; n < 60; n++) begin
      if (n % 10 == 0) begin
        cfgWait   = 24'($urandom);
        cfgWide   = 6'($urandom);
        cfgStrobe = 6'($urandom);
      end
      runAccess(1'($urandom), {3'($urandom % 8), 24'($urandom)}, $urandom,
                ($urandom % 3 == 0) ? int'($urandom % 20) : 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule